// File: doc/BRIEF.md
# Multi-Bus Region Permission Fault Checker

This block watches every CPU memory access on four buses and decides, one access at a time, whether the access is permitted. There is one instruction-fetch bus, two independent data-read buses and one data-write bus. Each data access carries an address and a context tag. A bank of programmable permission regions is compared against it. Every region has a base, an inclusive limit, a context tag, an enable and separate read and write grants. A data access is legal only when exactly one region grants it. No grant is a fault, and two or more overlapping grants are also a fault.

A fetch is legal when its address falls inside a fixed hardwired protected window set at build time, or inside one of a small number of programmable open windows that is currently enabled. Each bus has its own registered fault pulse. The pulse comes with a CPU-side fault type code and the address that faulted, so that the CPU fault logic can tell which bus complained. A plain single-word write port programs all region and window registers.

Top module: `rpg_guard`

## Requirements
- R1: A valid access on read bus 0 faults unless exactly one region matches it. A region matches when all of these hold: its enable bit is set, its read grant is set, its tag equals the access tag, and base <= address <= limit. Zero matches fault, and two or more matches fault.
- R2: A valid access on the write bus follows the same exactly-one rule, using the write grant in place of the read grant.
- R3: Read bus 1 is checked by its own logic against the same regions. Its fault output is independent of read bus 0, so both read buses can fault in the same cycle.
- R4: A valid fetch faults only when its address is outside the fixed window [PROT_LO, PROT_HI] and also outside every enabled open window (base <= address <= limit, enable set).
- R5: While a bus's fault pulse is high, its code output reads 8'h01 and its address output holds the address of the faulting access. While the pulse is low, the code output reads 8'h00.
- R6: A fault pulse rises in the cycle after the clock edge that sampled the valid access and lasts one cycle per faulting access. When valid is low, no fault is produced.
- R7: Configuration is written one word per cycle. Region i field f sits at word i*4+f and open window j field f at word (NUM_RGN+j)*4+f. Field 0 is the base, field 1 is the limit and field 2 is the attribute. The region attribute holds enable in bit 0, read in bit 1, write in bit 2 and the tag in bits [4+TAGW-1:4]. The window attribute holds enable in bit 0. A write takes effect from the next cycle, so an access in the same cycle is judged against the old values.
- R8: After reset, all regions and open windows are disabled and all fault outputs are low. Every data access therefore faults, and only fetches inside the fixed window pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word index |
| cfg_wdata | input | AW | Configuration write data |
| pf_vld | input | 1 | Fetch access valid |
| pf_addr | input | AW | Fetch address |
| dr0_vld | input | 1 | Read bus 0 access valid |
| dr0_addr | input | AW | Read bus 0 address |
| dr0_tag | input | TAGW | Read bus 0 context tag |
| dr1_vld | input | 1 | Read bus 1 access valid |
| dr1_addr | input | AW | Read bus 1 address |
| dr1_tag | input | TAGW | Read bus 1 context tag |
| dw_vld | input | 1 | Write bus access valid |
| dw_addr | input | AW | Write bus address |
| dw_tag | input | TAGW | Write bus context tag |
| pf_flt | output | 1 | Fetch fault pulse |
| pf_flt_code | output | 8 | Fetch fault type code |
| pf_flt_addr | output | AW | Fetch faulting address |
| dr0_flt | output | 1 | Read bus 0 fault pulse |
| dr0_flt_code | output | 8 | Read bus 0 fault type code |
| dr0_flt_addr | output | AW | Read bus 0 faulting address |
| dr1_flt | output | 1 | Read bus 1 fault pulse |
| dr1_flt_code | output | 8 | Read bus 1 fault type code |
| dr1_flt_addr | output | AW | Read bus 1 faulting address |
| dw_flt | output | 1 | Write bus fault pulse |
| dw_flt_code | output | 8 | Write bus fault type code |
| dw_flt_addr | output | AW | Write bus faulting address |

## Verification
The bench builds the block with four regions, two open windows, 8-bit addresses and 2-bit tags, and a fixed window of 0x08..0x17. With these values every address and every tag can be swept on all four buses at once under several region layouts. The layouts cover overlapping grants, single-address regions, inverted bounds, disabled regions, grants for only one direction and tag mismatches. Read bus 1 is always driven with a different address and tag than read bus 0, which shows the two read checks are independent. A configuration write is issued in the same cycle as an access to show that the new values take effect one cycle later.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  // CPU-side protection fault type code
  localparam logic [7:0] CPU_FLT_CODE = 8'h01;
  localparam logic [7:0] NO_FLT_CODE  = 8'h00;

  // Configuration words per region / open window slot
  localparam int WORDS_PER_SLOT = 4;
  localparam int FLD_BASE  = 0;
  localparam int FLD_LIMIT = 1;
  localparam int FLD_ATTR  = 2;

  // Attribute bit positions
  localparam int ATTR_EN      = 0;
  localparam int ATTR_RD      = 1;
  localparam int ATTR_WR      = 2;
  localparam int ATTR_TAG_LSB = 4;
endpackage

// File: rtl/rpg_rst_sync.sv
module rpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/rpg_cfg_regs.sv
module rpg_cfg_regs
  import rpg_pkg::*;
#(
  parameter int NUM_RGN  = 8,
  parameter int NUM_OPEN = 2,
  parameter int AW       = 32,
  parameter int TAGW     = 4,
  parameter int CFG_AW   = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [CFG_AW-1:0]              cfg_addr,
  input  logic [AW-1:0]                  cfg_wdata,
  output logic [NUM_RGN-1:0][AW-1:0]     rgn_base,
  output logic [NUM_RGN-1:0][AW-1:0]     rgn_limit,
  output logic [NUM_RGN-1:0]             rgn_en,
  output logic [NUM_RGN-1:0]             rgn_rd,
  output logic [NUM_RGN-1:0]             rgn_wr,
  output logic [NUM_RGN-1:0][TAGW-1:0]   rgn_tag,
  output logic [NUM_OPEN-1:0][AW-1:0]    opn_base,
  output logic [NUM_OPEN-1:0][AW-1:0]    opn_limit,
  output logic [NUM_OPEN-1:0]            opn_en
);

  // Permission regions
  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    localparam logic [CFG_AW-1:0] A_BASE = CFG_AW'(g * WORDS_PER_SLOT + FLD_BASE);
    localparam logic [CFG_AW-1:0] A_LIM  = CFG_AW'(g * WORDS_PER_SLOT + FLD_LIMIT);
    localparam logic [CFG_AW-1:0] A_ATTR = CFG_AW'(g * WORDS_PER_SLOT + FLD_ATTR);

    logic            we_base, we_lim, we_attr;
    logic [AW-1:0]   base_q, lim_q;
    logic            en_q, rd_q, wr_q;
    logic [TAGW-1:0] tag_q;

    always_comb begin
      we_base = cfg_we && (cfg_addr == A_BASE);
      we_lim  = cfg_we && (cfg_addr == A_LIM);
      we_attr = cfg_we && (cfg_addr == A_ATTR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        lim_q  <= '0;
        en_q   <= 1'b0;
        rd_q   <= 1'b0;
        wr_q   <= 1'b0;
        tag_q  <= '0;
      end else begin
        if (we_base) base_q <= cfg_wdata;
        if (we_lim)  lim_q  <= cfg_wdata;
        if (we_attr) begin
          en_q  <= cfg_wdata[ATTR_EN];
          rd_q  <= cfg_wdata[ATTR_RD];
          wr_q  <= cfg_wdata[ATTR_WR];
          tag_q <= cfg_wdata[ATTR_TAG_LSB +: TAGW];
        end
      end
    end

    assign rgn_base[g]  = base_q;
    assign rgn_limit[g] = lim_q;
    assign rgn_en[g]    = en_q;
    assign rgn_rd[g]    = rd_q;
    assign rgn_wr[g]    = wr_q;
    assign rgn_tag[g]   = tag_q;
  end

  // Open fetch windows
  for (genvar j = 0; j < NUM_OPEN; j++) begin : g_opn
    localparam int SLOT = NUM_RGN + j;
    localparam logic [CFG_AW-1:0] A_BASE = CFG_AW'(SLOT * WORDS_PER_SLOT + FLD_BASE);
    localparam logic [CFG_AW-1:0] A_LIM  = CFG_AW'(SLOT * WORDS_PER_SLOT + FLD_LIMIT);
    localparam logic [CFG_AW-1:0] A_ATTR = CFG_AW'(SLOT * WORDS_PER_SLOT + FLD_ATTR);

    logic          we_base, we_lim, we_attr;
    logic [AW-1:0] base_q, lim_q;
    logic          en_q;

    always_comb begin
      we_base = cfg_we && (cfg_addr == A_BASE);
      we_lim  = cfg_we && (cfg_addr == A_LIM);
      we_attr = cfg_we && (cfg_addr == A_ATTR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        lim_q  <= '0;
        en_q   <= 1'b0;
      end else begin
        if (we_base) base_q <= cfg_wdata;
        if (we_lim)  lim_q  <= cfg_wdata;
        if (we_attr) en_q   <= cfg_wdata[ATTR_EN];
      end
    end

    assign opn_base[j]  = base_q;
    assign opn_limit[j] = lim_q;
    assign opn_en[j]    = en_q;
  end

endmodule

// File: rtl/rpg_data_chk.sv
module rpg_data_chk
  import rpg_pkg::*;
#(
  parameter int NUM_RGN = 8,
  parameter int AW      = 32,
  parameter int TAGW    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc_vld,
  input  logic [AW-1:0]                acc_addr,
  input  logic [TAGW-1:0]              acc_tag,
  input  logic [NUM_RGN-1:0][AW-1:0]   rgn_base,
  input  logic [NUM_RGN-1:0][AW-1:0]   rgn_limit,
  input  logic [NUM_RGN-1:0]           rgn_en,
  input  logic [NUM_RGN-1:0]           rgn_perm,
  input  logic [NUM_RGN-1:0][TAGW-1:0] rgn_tag,
  output logic                         flt,
  output logic [7:0]                   flt_code,
  output logic [AW-1:0]                flt_addr
);
  localparam logic [NUM_RGN-1:0] ONE_V = NUM_RGN'(1);

  logic [NUM_RGN-1:0] hit;
  logic               any_hit;
  logic               multi_hit;
  logic               flt_d;
  logic [7:0]         code_d;

  // Per-region match vector
  for (genvar g = 0; g < NUM_RGN; g++) begin : g_hit
    assign hit[g] = rgn_en[g] && rgn_perm[g] && (rgn_tag[g] == acc_tag) &&
                    (acc_addr >= rgn_base[g]) && (acc_addr <= rgn_limit[g]);
  end

  // Exactly-one test: nonzero and no second bit set
  always_comb begin
    any_hit   = |hit;
    multi_hit = |(hit & (hit - ONE_V));
    flt_d     = acc_vld && (!any_hit || multi_hit);
    code_d    = flt_d ? CPU_FLT_CODE : NO_FLT_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt      <= 1'b0;
      flt_code <= NO_FLT_CODE;
      flt_addr <= '0;
    end else begin
      flt      <= flt_d;
      flt_code <= code_d;
      if (flt_d) flt_addr <= acc_addr;
    end
  end
endmodule

// File: rtl/rpg_fetch_chk.sv
module rpg_fetch_chk
  import rpg_pkg::*;
#(
  parameter int            NUM_OPEN = 2,
  parameter int            AW       = 32,
  parameter logic [AW-1:0] PROT_LO  = '0,
  parameter logic [AW-1:0] PROT_HI  = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_vld,
  input  logic [AW-1:0]               acc_addr,
  input  logic [NUM_OPEN-1:0][AW-1:0] opn_base,
  input  logic [NUM_OPEN-1:0][AW-1:0] opn_limit,
  input  logic [NUM_OPEN-1:0]         opn_en,
  output logic                        flt,
  output logic [7:0]                  flt_code,
  output logic [AW-1:0]               flt_addr
);
  logic [NUM_OPEN-1:0] opn_hit;
  logic                in_fixed;
  logic                flt_d;
  logic [7:0]          code_d;

  for (genvar j = 0; j < NUM_OPEN; j++) begin : g_opn_hit
    assign opn_hit[j] = opn_en[j] && (acc_addr >= opn_base[j]) &&
                        (acc_addr <= opn_limit[j]);
  end

  always_comb begin
    in_fixed = (acc_addr >= PROT_LO) && (acc_addr <= PROT_HI);
    flt_d    = acc_vld && !in_fixed && !(|opn_hit);
    code_d   = flt_d ? CPU_FLT_CODE : NO_FLT_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt      <= 1'b0;
      flt_code <= NO_FLT_CODE;
      flt_addr <= '0;
    end else begin
      flt      <= flt_d;
      flt_code <= code_d;
      if (flt_d) flt_addr <= acc_addr;
    end
  end
endmodule

// File: rtl/rpg_guard.sv
module rpg_guard
  import rpg_pkg::*;
#(
  parameter int            NUM_RGN  = 8,
  parameter int            NUM_OPEN = 2,
  parameter int            AW       = 32,
  parameter int            TAGW     = 4,
  parameter logic [AW-1:0] PROT_LO  = AW'(32'h0000_1000),
  parameter logic [AW-1:0] PROT_HI  = AW'(32'h0000_1FFF),
  localparam int           CFG_AW   = $clog2((NUM_RGN + NUM_OPEN) * WORDS_PER_SLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              pf_vld,
  input  logic [AW-1:0]     pf_addr,
  input  logic              dr0_vld,
  input  logic [AW-1:0]     dr0_addr,
  input  logic [TAGW-1:0]   dr0_tag,
  input  logic              dr1_vld,
  input  logic [AW-1:0]     dr1_addr,
  input  logic [TAGW-1:0]   dr1_tag,
  input  logic              dw_vld,
  input  logic [AW-1:0]     dw_addr,
  input  logic [TAGW-1:0]   dw_tag,
  output logic              pf_flt,
  output logic [7:0]        pf_flt_code,
  output logic [AW-1:0]     pf_flt_addr,
  output logic              dr0_flt,
  output logic [7:0]        dr0_flt_code,
  output logic [AW-1:0]     dr0_flt_addr,
  output logic              dr1_flt,
  output logic [7:0]        dr1_flt_code,
  output logic [AW-1:0]     dr1_flt_addr,
  output logic              dw_flt,
  output logic [7:0]        dw_flt_code,
  output logic [AW-1:0]     dw_flt_addr
);

  logic                         rst_sync_n;
  logic [NUM_RGN-1:0][AW-1:0]   rgn_base;
  logic [NUM_RGN-1:0][AW-1:0]   rgn_limit;
  logic [NUM_RGN-1:0]           rgn_en;
  logic [NUM_RGN-1:0]           rgn_rd;
  logic [NUM_RGN-1:0]           rgn_wr;
  logic [NUM_RGN-1:0][TAGW-1:0] rgn_tag;
  logic [NUM_OPEN-1:0][AW-1:0]  opn_base;
  logic [NUM_OPEN-1:0][AW-1:0]  opn_limit;
  logic [NUM_OPEN-1:0]          opn_en;

  rpg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rpg_cfg_regs #(
    .NUM_RGN  (NUM_RGN),
    .NUM_OPEN (NUM_OPEN),
    .AW       (AW),
    .TAGW     (TAGW),
    .CFG_AW   (CFG_AW)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .rgn_base  (rgn_base),
    .rgn_limit (rgn_limit),
    .rgn_en    (rgn_en),
    .rgn_rd    (rgn_rd),
    .rgn_wr    (rgn_wr),
    .rgn_tag   (rgn_tag),
    .opn_base  (opn_base),
    .opn_limit (opn_limit),
    .opn_en    (opn_en)
  );

  rpg_fetch_chk #(
    .NUM_OPEN (NUM_OPEN),
    .AW       (AW),
    .PROT_LO  (PROT_LO),
    .PROT_HI  (PROT_HI)
  ) u_pf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc_vld   (pf_vld),
    .acc_addr  (pf_addr),
    .opn_base  (opn_base),
    .opn_limit (opn_limit),
    .opn_en    (opn_en),
    .flt       (pf_flt),
    .flt_code  (pf_flt_code),
    .flt_addr  (pf_flt_addr)
  );

  rpg_data_chk #(
    .NUM_RGN (NUM_RGN),
    .AW      (AW),
    .TAGW    (TAGW)
  ) u_dr0 (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc_vld   (dr0_vld),
    .acc_addr  (dr0_addr),
    .acc_tag   (dr0_tag),
    .rgn_base  (rgn_base),
    .rgn_limit (rgn_limit),
    .rgn_en    (rgn_en),
    .rgn_perm  (rgn_rd),
    .rgn_tag   (rgn_tag),
    .flt       (dr0_flt),
    .flt_code  (dr0_flt_code),
    .flt_addr  (dr0_flt_addr)
  );

  rpg_data_chk #(
    .NUM_RGN (NUM_RGN),
    .AW      (AW),
    .TAGW    (TAGW)
  ) u_dr1 (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc_vld   (dr1_vld),
    .acc_addr  (dr1_addr),
    .acc_tag   (dr1_tag),
    .rgn_base  (rgn_base),
    .rgn_limit (rgn_limit),
    .rgn_en    (rgn_en),
    .rgn_perm  (rgn_rd),
    .rgn_tag   (rgn_tag),
    .flt       (dr1_flt),
    .flt_code  (dr1_flt_code),
    .flt_addr  (dr1_flt_addr)
  );

  rpg_data_chk #(
    .NUM_RGN (NUM_RGN),
    .AW      (AW),
    .TAGW    (TAGW)
  ) u_dw (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc_vld   (dw_vld),
    .acc_addr  (dw_addr),
    .acc_tag   (dw_tag),
    .rgn_base  (rgn_base),
    .rgn_limit (rgn_limit),
    .rgn_en    (rgn_en),
    .rgn_perm  (rgn_wr),
    .rgn_tag   (rgn_tag),
    .flt       (dw_flt),
    .flt_code  (dw_flt_code),
    .flt_addr  (dw_flt_addr)
  );

endmodule

// File: rtl/rpg_guard_chk.sv
module rpg_guard_chk #(
  parameter int            AW      = 32,
  parameter logic [AW-1:0] PROT_LO = '0,
  parameter logic [AW-1:0] PROT_HI = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pf_vld,
  input logic [AW-1:0] pf_addr,
  input logic          dr0_vld,
  input logic [AW-1:0] dr0_addr,
  input logic          dr1_vld,
  input logic [AW-1:0] dr1_addr,
  input logic          dw_vld,
  input logic [AW-1:0] dw_addr,
  input logic          pf_flt,
  input logic [7:0]    pf_flt_code,
  input logic [AW-1:0] pf_flt_addr,
  input logic          dr0_flt,
  input logic [7:0]    dr0_flt_code,
  input logic [AW-1:0] dr0_flt_addr,
  input logic          dr1_flt,
  input logic [7:0]    dr1_flt_code,
  input logic [AW-1:0] dr1_flt_addr,
  input logic          dw_flt,
  input logic [7:0]    dw_flt_code,
  input logic [AW-1:0] dw_flt_addr
);
  // R6: a fault only follows a sampled valid access
  a_r6_pf_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
    pf_flt |-> $past(pf_vld));
  a_r6_dr0_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
    dr0_flt |-> $past(dr0_vld));
  a_r6_dr1_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
    dr1_flt |-> $past(dr1_vld));
  a_r6_dw_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
    dw_flt |-> $past(dw_vld));

  // R5: code and address accompany each pulse
  a_r5_pf_code: assert property (@(posedge clk) disable iff (!rst_n)
    pf_flt_code == (pf_flt ? 8'h01 : 8'h00));
  a_r5_dr0_code: assert property (@(posedge clk) disable iff (!rst_n)
    dr0_flt_code == (dr0_flt ? 8'h01 : 8'h00));
  a_r5_dr1_code: assert property (@(posedge clk) disable iff (!rst_n)
    dr1_flt_code == (dr1_flt ? 8'h01 : 8'h00));
  a_r5_dw_code: assert property (@(posedge clk) disable iff (!rst_n)
    dw_flt_code == (dw_flt ? 8'h01 : 8'h00));
  a_r5_pf_addr: assert property (@(posedge clk) disable iff (!rst_n)
    pf_flt |-> pf_flt_addr == $past(pf_addr));
  a_r5_dr0_addr: assert property (@(posedge clk) disable iff (!rst_n)
    dr0_flt |-> dr0_flt_addr == $past(dr0_addr));
  a_r5_dr1_addr: assert property (@(posedge clk) disable iff (!rst_n)
    dr1_flt |-> dr1_flt_addr == $past(dr1_addr));
  a_r5_dw_addr: assert property (@(posedge clk) disable iff (!rst_n)
    dw_flt |-> dw_flt_addr == $past(dw_addr));
  // R5: the latched address holds between faults
  a_r5_dr0_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dr0_flt |-> $stable(dr0_flt_addr) || $past(!rst_n));

  // R4: fetches inside the fixed window never fault
  a_r4_fixed_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_vld && pf_addr >= PROT_LO && pf_addr <= PROT_HI) |=> !pf_flt);
endmodule

bind rpg_guard rpg_guard_chk #(
  .AW      (AW),
  .PROT_LO (PROT_LO),
  .PROT_HI (PROT_HI)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pf_vld       (pf_vld),
  .pf_addr      (pf_addr),
  .dr0_vld      (dr0_vld),
  .dr0_addr     (dr0_addr),
  .dr1_vld      (dr1_vld),
  .dr1_addr     (dr1_addr),
  .dw_vld       (dw_vld),
  .dw_addr      (dw_addr),
  .pf_flt       (pf_flt),
  .pf_flt_code  (pf_flt_code),
  .pf_flt_addr  (pf_flt_addr),
  .dr0_flt      (dr0_flt),
  .dr0_flt_code (dr0_flt_code),
  .dr0_flt_addr (dr0_flt_addr),
  .dr1_flt      (dr1_flt),
  .dr1_flt_code (dr1_flt_code),
  .dr1_flt_addr (dr1_flt_addr),
  .dw_flt       (dw_flt),
  .dw_flt_code  (dw_flt_code),
  .dw_flt_addr  (dw_flt_addr)
);

// File: tb/rpg_guard_tb_top.sv
`timescale 1ns/1ps
module rpg_guard_tb_top;
  localparam int NR = 4;
  localparam int NO = 2;
  localparam int AW = 8;
  localparam int TW = 2;
  localparam int CAW = 5;
  localparam logic [7:0] PLO = 8'h08;
  localparam logic [7:0] PHI = 8'h17;

  logic clk, rst_n;
  logic cfg_we;
  logic [CAW-1:0] cfg_addr;
  logic [AW-1:0] cfg_wdata;
  logic pf_vld, dr0_vld, dr1_vld, dw_vld;
  logic [AW-1:0] pf_addr, dr0_addr, dr1_addr, dw_addr;
  logic [TW-1:0] dr0_tag, dr1_tag, dw_tag;
  logic pf_flt, dr0_flt, dr1_flt, dw_flt;
  logic [7:0] pf_flt_code, dr0_flt_code, dr1_flt_code, dw_flt_code;
  logic [AW-1:0] pf_flt_addr, dr0_flt_addr, dr1_flt_addr, dw_flt_addr;

  rpg_guard #(
    .NUM_RGN(NR), .NUM_OPEN(NO), .AW(AW), .TAGW(TW),
    .PROT_LO(PLO), .PROT_HI(PHI)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pf_vld(pf_vld), .pf_addr(pf_addr),
    .dr0_vld(dr0_vld), .dr0_addr(dr0_addr), .dr0_tag(dr0_tag),
    .dr1_vld(dr1_vld), .dr1_addr(dr1_addr), .dr1_tag(dr1_tag),
    .dw_vld(dw_vld), .dw_addr(dw_addr), .dw_tag(dw_tag),
    .pf_flt(pf_flt), .pf_flt_code(pf_flt_code), .pf_flt_addr(pf_flt_addr),
    .dr0_flt(dr0_flt), .dr0_flt_code(dr0_flt_code), .dr0_flt_addr(dr0_flt_addr),
    .dr1_flt(dr1_flt), .dr1_flt_code(dr1_flt_code), .dr1_flt_addr(dr1_flt_addr),
    .dw_flt(dw_flt), .dw_flt_code(dw_flt_code), .dw_flt_addr(dw_flt_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit fin = 0;

  // Bench-side model of the programmed configuration
  logic [7:0] m_base [NR];
  logic [7:0] m_lim  [NR];
  bit         m_en   [NR];
  bit         m_rd   [NR];
  bit         m_wr   [NR];
  logic [1:0] m_tag  [NR];
  logic [7:0] o_base [NO];
  logic [7:0] o_lim  [NO];
  bit         o_en   [NO];

  function automatic bit exp_dflt(input logic [7:0] a, input logic [1:0] t, input bit wr);
    int n = 0;
    for (int i = 0; i < NR; i++)
      if (m_en[i] && (wr ? m_wr[i] : m_rd[i]) && m_tag[i] == t &&
          a >= m_base[i] && a <= m_lim[i]) n++;
    return n != 1;
  endfunction

  function automatic bit exp_pflt(input logic [7:0] a);
    if (a >= PLO && a <= PHI) return 1'b0;
    for (int j = 0; j < NO; j++)
      if (o_en[j] && a >= o_base[j] && a <= o_lim[j]) return 1'b0;
    return 1'b1;
  endfunction

  // R7: word i*4+f, fields base/limit/attr; attr en[0] rd[1] wr[2] tag[5:4]
  function automatic void model_apply(input int idx, input logic [7:0] d);
    int slot = idx / 4;
    int f = idx % 4;
    if (slot < NR) begin
      if (f == 0) m_base[slot] = d;
      else if (f == 1) m_lim[slot] = d;
      else if (f == 2) begin
        m_en[slot] = d[0]; m_rd[slot] = d[1]; m_wr[slot] = d[2]; m_tag[slot] = d[5:4];
      end
    end else if (slot < NR + NO) begin
      if (f == 0) o_base[slot-NR] = d;
      else if (f == 1) o_lim[slot-NR] = d;
      else if (f == 2) o_en[slot-NR] = d[0];
    end
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = CAW'(idx); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    model_apply(idx, d);
  endtask

  task automatic set_rgn(input int i, input logic [7:0] b, input logic [7:0] l,
                         input bit en, input bit rd, input bit wr, input logic [1:0] tg);
    cfg_wr(i*4+0, b);
    cfg_wr(i*4+1, l);
    cfg_wr(i*4+2, {2'b00, tg, 1'b0, wr, rd, en});
  endtask

  task automatic set_opn(input int j, input logic [7:0] b, input logic [7:0] l, input bit en);
    cfg_wr((NR+j)*4+0, b);
    cfg_wr((NR+j)*4+1, l);
    cfg_wr((NR+j)*4+2, {7'd0, en});
  endtask

  task automatic chk_bus(input string req, input string nm, input bit e,
                         input logic f, input logic [7:0] c, input logic [7:0] fa,
                         input logic [7:0] a);
    chk(req, {nm, "_flt"}, 32'(f), 32'(e));
    chk("R5", {nm, "_code"}, 32'(c), e ? 32'h01 : 32'h00);
    if (e) chk("R5", {nm, "_addr"}, 32'(fa), 32'(a));
  endtask

  // One access cycle on all four buses, optionally with a config write
  task automatic access(input bit v, input logic [7:0] pa,
                        input logic [7:0] a0, input logic [1:0] t0,
                        input logic [7:0] a1, input logic [1:0] t1,
                        input logic [7:0] aw, input logic [1:0] tw,
                        input bit do_cfg, input int cidx, input logic [7:0] cdat);
    bit ep, e0, e1, ew;
    ep = v && exp_pflt(pa);
    e0 = v && exp_dflt(a0, t0, 1'b0);
    e1 = v && exp_dflt(a1, t1, 1'b0);
    ew = v && exp_dflt(aw, tw, 1'b1);
    @(negedge clk);
    pf_vld = v; dr0_vld = v; dr1_vld = v; dw_vld = v;
    pf_addr = pa; dr0_addr = a0; dr0_tag = t0;
    dr1_addr = a1; dr1_tag = t1; dw_addr = aw; dw_tag = tw;
    cfg_we = do_cfg; cfg_addr = CAW'(cidx); cfg_wdata = cdat;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (do_cfg) model_apply(cidx, cdat);
    chk_bus(v ? "R4" : "R6", "pf", ep, pf_flt, pf_flt_code, pf_flt_addr, pa);
    chk_bus(v ? "R1" : "R6", "dr0", e0, dr0_flt, dr0_flt_code, dr0_flt_addr, a0);
    chk_bus(v ? "R3" : "R6", "dr1", e1, dr1_flt, dr1_flt_code, dr1_flt_addr, a1);
    chk_bus(v ? "R2" : "R6", "dw", ew, dw_flt, dw_flt_code, dw_flt_addr, aw);
  endtask

  task automatic sweep();
    for (int a = 0; a < 256; a++) begin
      for (int t = 0; t < 4; t++) begin
        bit v;
        logic [7:0] ab;
        logic [1:0] tb;
        v = ((a*4 + t) % 7) != 3;
        ab = a[7:0];
        tb = t[1:0];
        access(v, ab, ab, tb, ab ^ 8'h5A, tb ^ 2'b01, ab, tb, 1'b0, 0, 8'h00);
      end
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pf_vld = 1'b0; dr0_vld = 1'b0; dr1_vld = 1'b0; dw_vld = 1'b0;
    pf_addr = '0; dr0_addr = '0; dr1_addr = '0; dw_addr = '0;
    dr0_tag = '0; dr1_tag = '0; dw_tag = '0;
    for (int i = 0; i < NR; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_en[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_tag[i] = '0;
    end
    for (int j = 0; j < NO; j++) begin
      o_base[j] = '0; o_lim[j] = '0; o_en[j] = 0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R8: outputs quiet after reset
    chk("R8", "pf_flt", 32'(pf_flt), 0);
    chk("R8", "dr0_flt", 32'(dr0_flt), 0);
    chk("R8", "dr1_flt", 32'(dr1_flt), 0);
    chk("R8", "dw_flt", 32'(dw_flt), 0);
    chk("R8", "dr0_code", 32'(dr0_flt_code), 0);

    // R8: reset configuration sweep (all data accesses fault)
    sweep();

    // Layout 1: overlaps, direction-only grants, open windows
    set_rgn(0, 8'h10, 8'h3F, 1, 1, 1, 2'd0);
    set_rgn(1, 8'h30, 8'h7F, 1, 1, 0, 2'd0);
    set_rgn(2, 8'h80, 8'hFF, 1, 1, 1, 2'd1);
    set_rgn(3, 8'h00, 8'hFF, 1, 0, 1, 2'd2);
    set_opn(0, 8'h40, 8'h4F, 1);
    set_opn(1, 8'hF0, 8'hFF, 1);
    sweep();

    // Layout 2: single-address region, inverted bounds, disabled entries
    set_rgn(0, 8'h20, 8'h20, 1, 1, 1, 2'd3);
    set_rgn(1, 8'h7F, 8'h30, 1, 1, 1, 2'd0);
    set_rgn(3, 8'h00, 8'hFF, 0, 1, 1, 2'd2);
    set_opn(0, 8'h40, 8'h4F, 0);
    sweep();

    // R7: disabling region 0 in the same cycle as an access leaves that access passing
    access(1'b1, 8'h10, 8'h20, 2'd3, 8'h20, 2'd3, 8'h20, 2'd3, 1'b1, 0*4+2, 8'h00);
    chk("R7", "dr0_flt same-cycle write", 32'(dr0_flt), 0);
    access(1'b1, 8'h10, 8'h20, 2'd3, 8'h20, 2'd3, 8'h20, 2'd3, 1'b0, 0, 8'h00);
    chk("R7", "dr0_flt after write", 32'(dr0_flt), 1);

    // R6: pulse drops when valid drops
    access(1'b0, 8'h00, 8'h00, 2'd0, 8'h00, 2'd0, 8'h00, 2'd0, 1'b0, 0, 8'h00);
    chk("R6", "dr0_flt idle", 32'(dr0_flt), 0);

    fin = 1;
    finish_run();
  end
endmodule